// File: doc/BRIEF.md
# SRAM Chip-Enable Write-Protect Controller

This block sits between a host and an external static RAM that is kept alive by backup cells. It passes the host's active-low chip enable to the memory while the main supply is healthy. When a supply fault is flagged, it closes that path, so that a brown-out cannot corrupt stored data. An access that is already running when the fault appears may finish. That grace period is bounded by a timeout, after which the memory is locked out regardless. When the supply comes back, the memory stays locked for a recovery interval, which gives the host time to settle.

The supply and cell comparators sit outside the block and arrive as synchronous flags. The block reports which source should feed the memory rail: the main supply, the first backup cell or the second backup cell. The first cell is preferred while it is above its minimum. The block also keeps the cells disconnected from a fresh install until the first good power-up. A later power-down can restore that disconnected state if the host parks its chip-enable line at a mid-supply level long enough in the window between the fault threshold and the switchover threshold. All time intervals are cycle counts derived from a clock-frequency parameter.

Top module: `nvsram_ce_guard`

## Requirements
- R1: In the pass-through state, `ram_ce_n` equals `host_ce_n` in the same cycle, including changes between clock edges.
- R2: Once `pwr_ok` is low and no access is in progress (`host_ce_n` high at the sampling edge), `ram_ce_n` is high from the next edge on, whatever `host_ce_n` does.
- R3: If `host_ce_n` is low at the edge where `pwr_ok` is first seen low, `ram_ce_n` keeps following `host_ce_n` until the host releases it. After that it stays high even if the host asserts again.
- R4: An access still active at fault time is cut off after WPT_CYC cycles. `ram_ce_n` follows the host for WPT_CYC edges after the fault edge, then is forced high.
- R5: After `pwr_ok` is seen high (from power-down or from the isolated state), `ram_ce_n` stays high for REC_CYC cycles. Pass-through resumes at the next edge.
- R6: `tol_mode` reports the tolerance strap `tol_sel` unchanged (0 = tight 5% trip, 1 = wide 10% trip).
- R7: `src_sel` encodes 2'b00 = none, 2'b01 = main supply, 2'b10 = cell 1, 2'b11 = cell 2. When not isolated, it is 2'b01 while `above_swo` is high. Otherwise it is 2'b10 if `cell1_ok` is high and 2'b11 if it is low.
- R8: Reset enters the isolated state: `isolated` = 1, `ram_ce_n` = 1, `src_sel` = 2'b00. These hold, whatever `host_ce_n` and `above_swo` do, until `pwr_ok` is seen high; the next cycle reports `isolated` = 0.
- R9: During a power-down, suppose `ce_mid` is high for at least QUAL_CYC consecutive edges while `pwr_ok` is low and `above_swo` is high, and `above_swo` then falls. The block then re-enters the isolated state one edge later (`isolated` = 1, `src_sel` = 2'b00, `ram_ce_n` = 1).
- R10: Isolation is not re-armed if `ce_over` is high at any edge of that window, or if `ce_mid` is held for fewer than QUAL_CYC consecutive edges. In both cases the rail then moves to a backup cell.
- R11: If `pwr_ok` drops during the recovery interval, the memory stays locked. The full REC_CYC interval starts again on the next return of power.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_ce_n | input | 1 | Host chip enable, active low |
| pwr_ok | input | 1 | Supply above power-fail threshold |
| above_swo | input | 1 | Supply above backup switchover level |
| tol_sel | input | 1 | Tolerance strap (0 = 5%, 1 = 10%) |
| cell1_ok | input | 1 | Backup cell 1 above its minimum voltage |
| ce_mid | input | 1 | Chip-enable line sits inside the mid-supply band |
| ce_over | input | 1 | Chip-enable line is above the mid-supply band |
| ram_ce_n | output | 1 | Conditioned chip enable to the SRAM, active low |
| tol_mode | output | 1 | Tolerance mode bit to the comparator interface |
| src_sel | output | 2 | Memory rail source select |
| isolated | output | 1 | Backup cells disconnected from the outputs |

## Verification
The fault path is entered with the host idle, with the host mid-access and releasing early, and with the host holding the access past the timeout. Each case separates one of three behaviours: immediate lockout, grace period ending on release, and grace period ending on the timer. The isolation window is driven with a mid-level hold of exactly the qualifying length, with a hold one cycle short, and with a qualifying hold spoiled by one over-band sample. This pins down both the count boundary and the sticky cancel. Recovery is tested from a clean power-up and from a dip during recovery, so that a restarted interval can be told apart from a resumed one.

// File: rtl/nvsram_ce_guard.sv
`timescale 1ns/1ps
module nvsram_ce_guard #(
  parameter int CLK_HZ      = 100_000_000,
  parameter int WPT_NS      = 1500,
  parameter int RECOVER_US  = 120_000,
  parameter int ISO_QUAL_NS = 700
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_ce_n,
  input  logic       pwr_ok,
  input  logic       above_swo,
  input  logic       tol_sel,
  input  logic       cell1_ok,
  input  logic       ce_mid,
  input  logic       ce_over,
  output logic       ram_ce_n,
  output logic       tol_mode,
  output logic [1:0] src_sel,
  output logic       isolated
);
  localparam int KHZ      = CLK_HZ / 1000;
  localparam int WPT_RAW  = (KHZ * WPT_NS) / 1_000_000;
  localparam int REC_RAW  = (CLK_HZ / 1_000_000) * RECOVER_US;
  localparam int QUAL_RAW = (KHZ * ISO_QUAL_NS) / 1_000_000;
  localparam int WPT_CYC  = (WPT_RAW  < 1) ? 1 : WPT_RAW;
  localparam int REC_CYC  = (REC_RAW  < 1) ? 1 : REC_RAW;
  localparam int QUAL_CYC = (QUAL_RAW < 1) ? 1 : QUAL_RAW;
  localparam int TMR_MAX  = (WPT_CYC > REC_CYC) ? WPT_CYC : REC_CYC;
  localparam int TW       = $clog2(TMR_MAX + 1);
  localparam int QW       = $clog2(QUAL_CYC + 1);

  typedef enum logic [2:0] {S_ISO, S_RECOV, S_RUN, S_DRAIN, S_PROT} st_t;

  st_t st, nxt;
  logic [TW-1:0] tmr;
  logic [QW-1:0] qcnt;
  logic armed, cancel;

  wire powered_down = (st == S_DRAIN) || (st == S_PROT);
  wire win          = !pwr_ok && above_swo && powered_down;
  wire iso_go       = !above_swo && armed && !cancel;

  always_comb begin
    nxt = st;
    case (st)
      S_ISO:   if (pwr_ok) nxt = S_RECOV;
      S_RECOV: if (!pwr_ok) nxt = S_PROT;
               else if (tmr == TW'(REC_CYC - 1)) nxt = S_RUN;
      S_RUN:   if (!pwr_ok) nxt = host_ce_n ? S_PROT : S_DRAIN;
      S_DRAIN: if (pwr_ok) nxt = S_RECOV;
               else if (iso_go) nxt = S_ISO;
               else if (host_ce_n || tmr == TW'(WPT_CYC - 1)) nxt = S_PROT;
      S_PROT:  if (pwr_ok) nxt = S_RECOV;
               else if (iso_go) nxt = S_ISO;
      default: nxt = S_ISO;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_ISO;
      tmr <= '0;
    end else begin
      st <= nxt;
      if (nxt != st) tmr <= '0;
      else if (st == S_RECOV || st == S_DRAIN) tmr <= tmr + TW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qcnt   <= '0;
      armed  <= 1'b0;
      cancel <= 1'b0;
    end else if (pwr_ok || st == S_ISO) begin
      qcnt   <= '0;
      armed  <= 1'b0;
      cancel <= 1'b0;
    end else if (win) begin
      if (ce_over) cancel <= 1'b1;
      if (!ce_mid) qcnt <= '0;
      else if (qcnt == QW'(QUAL_CYC - 1)) armed <= 1'b1;
      else qcnt <= qcnt + QW'(1);
    end
  end

  assign ram_ce_n = (st == S_RUN || st == S_DRAIN) ? host_ce_n : 1'b1;
  assign isolated = (st == S_ISO);
  assign tol_mode = tol_sel;
  assign src_sel  = isolated  ? 2'b00 :
                    above_swo ? 2'b01 :
                    cell1_ok  ? 2'b10 : 2'b11;
endmodule

module nvsram_ce_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pwr_ok,
  input logic       above_swo,
  input logic       ram_ce_n,
  input logic [1:0] src_sel,
  input logic       isolated
);
  p_iso_ce_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    isolated |-> ram_ce_n);

  p_iso_no_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    isolated |-> (src_sel == 2'b00));

  p_backup_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!isolated && !above_swo) |-> src_sel[1]);

  p_lock_on_return_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_ok) |=> ram_ce_n);

  p_fail_stays_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_ok && $past(!pwr_ok) && $past(ram_ce_n)) |-> ram_ce_n);

  p_iso_only_unpowered_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(isolated) |-> $past(!pwr_ok && !above_swo));
endmodule

bind nvsram_ce_guard nvsram_ce_guard_chk chk_i (
  .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .above_swo(above_swo),
  .ram_ce_n(ram_ce_n), .src_sel(src_sel), .isolated(isolated)
);

// File: tb/nvsram_ce_guard_tb.sv
`timescale 1ns/1ps
module nvsram_ce_guard_tb_top;
  localparam int WPT  = 20;
  localparam int REC  = 200;
  localparam int QUAL = 70;

  logic clk = 1'b0;
  logic rst_n, host_ce_n, pwr_ok, above_swo, tol_sel, cell1_ok, ce_mid, ce_over;
  logic ram_ce_n, tol_mode, isolated;
  logic [1:0] src_sel;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  nvsram_ce_guard #(
    .CLK_HZ(100_000_000), .WPT_NS(200), .RECOVER_US(2), .ISO_QUAL_NS(700)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .host_ce_n(host_ce_n), .pwr_ok(pwr_ok),
    .above_swo(above_swo), .tol_sel(tol_sel), .cell1_ok(cell1_ok),
    .ce_mid(ce_mid), .ce_over(ce_over), .ram_ce_n(ram_ce_n),
    .tol_mode(tol_mode), .src_sel(src_sel), .isolated(isolated)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic power_up(input string req);
    pwr_ok = 1'b1; above_swo = 1'b1; host_ce_n = 1'b0;
    step(1);
    check({req, " not isolated after return"}, isolated, 0);
    check({req, " src main"}, src_sel, 2'b01);
    step(REC - 1);
    #1 check({req, " lockout held to last cycle"}, ram_ce_n, 1);
    step(1);
    #1 check({req, " pass-through resumes"}, ram_ce_n, 0);
    host_ce_n = 1'b1;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; host_ce_n = 1'b0; pwr_ok = 1'b0; above_swo = 1'b0;
    tol_sel = 1'b0; cell1_ok = 1'b1; ce_mid = 1'b0; ce_over = 1'b0;
    step(2);
    check("R8 reset isolated", isolated, 1);
    check("R8 reset ce high", ram_ce_n, 1);
    check("R8 reset src none", src_sel, 2'b00);
    rst_n = 1'b1;
    above_swo = 1'b1;
    step(4);
    check("R8 isolation held without power", isolated, 1);
    check("R8 ce held high while isolated", ram_ce_n, 1);
    check("R8 src none while isolated", src_sel, 2'b00);
  endtask

  task automatic t_passthru;
    host_ce_n = 1'b0; #1 check("R1 follow low", ram_ce_n, 0);
    host_ce_n = 1'b1; #1 check("R1 follow high", ram_ce_n, 1);
    #1 host_ce_n = 1'b0; #1 check("R1 between edges low", ram_ce_n, 0);
    step(3);
    check("R1 hold low across edges", ram_ce_n, 0);
    host_ce_n = 1'b1; #1 check("R1 release", ram_ce_n, 1);
    step(1);
  endtask

  task automatic t_tol;
    tol_sel = 1'b1; #1 check("R6 wide mode", tol_mode, 1);
    tol_sel = 1'b0; #1 check("R6 tight mode", tol_mode, 0);
    step(1);
  endtask

  task automatic t_fail_idle;
    host_ce_n = 1'b1; pwr_ok = 1'b0;
    step(1);
    host_ce_n = 1'b0; #1 check("R2 forced high", ram_ce_n, 1);
    step(5);
    check("R2 still high", ram_ce_n, 1);
    check("R7 main source above switchover", src_sel, 2'b01);
    host_ce_n = 1'b1;
    power_up("R5");
  endtask

  task automatic t_fail_access;
    host_ce_n = 1'b0; pwr_ok = 1'b0;
    step(1);
    check("R3 access continues", ram_ce_n, 0);
    step(WPT / 2);
    check("R3 access still running", ram_ce_n, 0);
    host_ce_n = 1'b1; #1 check("R3 release seen", ram_ce_n, 1);
    step(1);
    host_ce_n = 1'b0; #1 check("R3 no new access", ram_ce_n, 1);
    host_ce_n = 1'b1;
    power_up("R5");
  endtask

  task automatic t_timeout;
    host_ce_n = 1'b0; pwr_ok = 1'b0;
    step(WPT);
    check("R4 last grace cycle", ram_ce_n, 0);
    step(1);
    check("R4 timeout forces high", ram_ce_n, 1);
    host_ce_n = 1'b1;
    power_up("R5");
  endtask

  task automatic t_src;
    pwr_ok = 1'b0;
    step(1);
    above_swo = 1'b0; cell1_ok = 1'b1; #1 check("R7 cell1 chosen", src_sel, 2'b10);
    cell1_ok = 1'b0; #1 check("R7 cell2 chosen", src_sel, 2'b11);
    cell1_ok = 1'b1; above_swo = 1'b1; #1 check("R7 back to main", src_sel, 2'b01);
    step(1);
    check("R7 not isolated", isolated, 0);
    power_up("R5");
  endtask

  task automatic t_iso_arm;
    pwr_ok = 1'b0;
    step(1);
    ce_mid = 1'b1;
    step(QUAL);
    ce_mid = 1'b0; above_swo = 1'b0;
    step(1);
    check("R9 isolated after qualified hold", isolated, 1);
    check("R9 src none", src_sel, 2'b00);
    host_ce_n = 1'b0; #1 check("R9 ce high while isolated", ram_ce_n, 1);
    host_ce_n = 1'b1;
    above_swo = 1'b1;
    step(2);
    check("R8 isolation held until power valid", isolated, 1);
    power_up("R8");
  endtask

  task automatic t_iso_cancel;
    pwr_ok = 1'b0;
    step(1);
    ce_mid = 1'b1;
    step(10);
    ce_over = 1'b1;
    step(1);
    ce_over = 1'b0;
    step(QUAL + 2);
    ce_mid = 1'b0; above_swo = 1'b0;
    step(1);
    check("R10 cancelled by over-band", isolated, 0);
    check("R10 backup cell after cancel", src_sel, 2'b10);
    power_up("R5");
  endtask

  task automatic t_iso_short;
    pwr_ok = 1'b0;
    step(1);
    ce_mid = 1'b1;
    step(QUAL - 1);
    ce_mid = 1'b0; above_swo = 1'b0;
    step(1);
    check("R10 short hold not armed", isolated, 0);
    check("R10 backup cell after short hold", src_sel, 2'b10);
    power_up("R5");
  endtask

  task automatic t_recov_drop;
    pwr_ok = 1'b0;
    step(1);
    pwr_ok = 1'b1;
    step(REC / 2);
    pwr_ok = 1'b0;
    step(1);
    host_ce_n = 1'b0; #1 check("R11 locked after dip", ram_ce_n, 1);
    host_ce_n = 1'b1;
    step(2);
    power_up("R11");
  endtask

  initial begin
    repeat (100_000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    t_reset();
    power_up("R5");
    t_passthru();
    t_tol();
    t_fail_idle();
    t_fail_access();
    t_timeout();
    t_src();
    t_iso_arm();
    t_iso_cancel();
    t_iso_short();
    t_recov_drop();
    summary();
  end
endmodule